// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

An 8-bit down counter for a small processor core. Software writes a preset value, which becomes both the reload value and the current count. It picks one of three count sources and starts or stops the counter. In time-base mode the count steps on a tick from a free-running clock prescaler. In event mode it steps on falling edges of an external flag input. In pulse-duration mode it steps on prescaler ticks only while a gate input is high.

When a step is taken from a count of zero, the counter reloads the preset and keeps running. This is an underflow: it gives a one-cycle pulse, sets a sticky interrupt request and toggles an output flop. That flop can be routed to a general-purpose output pin in place of a software-written level. Event counting continues while the processor core is paused. The clock-driven modes hold still during a pause.

Top module: `ptimer`

## Requirements
- R1: After reset the count, the preset, `irq`, `uf_pulse` and `q_out` are all 0 and the counter is stopped.
- R2: A cycle with `load_en` high writes `load_val` into the preset and the count; `cnt_val` shows the new value after that clock edge, and load wins over any step in the same cycle.
- R3: Mode 0 (time base): while running and not paused, the count steps down once every 32 clocks, so any run window of 32·k clocks takes exactly k steps.
- R4: Mode 1 (event): each falling edge of `evt_flag` steps the count once, after a two-flop synchronizer, and this also happens while `cpu_paused` is high.
- R5: In modes 0 and 2, the count does not change while `cpu_paused` is high.
- R6: A step taken at count 0 reloads the preset, gives exactly one cycle of `uf_pulse`, and sets `irq`; a preset of N therefore underflows once every N+1 steps.
- R7: `irq` stays high until a cycle with `irq_ack` high clears it.
- R8: A `stop` pulse freezes the count at its value and source events are then ignored; a later `start` pulse resumes from that value. Stop wins over start.
- R9: Mode 2 (pulse duration): while running, the count steps on prescaler ticks only while `gate_in` is high. The synchronized falling edge of the gate stops the counter and sets `irq`, and a later gate-high period does not count.
- R10: With `route_out` high, `q_out` toggles on each underflow; with `route_out` low, `q_out` is `gpo_val` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write preset and count |
| load_val | input | 8 | Value to write |
| mode_sel | input | 2 | 0 time base, 1 event, 2 pulse duration, 3 no counting |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse (priority over start) |
| cpu_paused | input | 1 | Processor core is paused |
| evt_flag | input | 1 | Asynchronous external event flag |
| gate_in | input | 1 | Asynchronous pulse-duration gate, active high |
| irq_ack | input | 1 | Clears the interrupt request |
| route_out | input | 1 | Selects the underflow toggle for `q_out` |
| gpo_val | input | 1 | Software level for `q_out` when not routed |
| cnt_val | output | 8 | Current count |
| irq | output | 1 | Sticky interrupt request |
| uf_pulse | output | 1 | One-cycle underflow pulse |
| q_out | output | 1 | General-purpose output pin |

## Verification
Suppose the run flag, the prescaler phase or the edge detector holds a wrong value. `cnt_val` then drifts from the step count predicted for a window of whole 32-clock periods, or for a known number of flag edges. That drift shows within one prescaler period, or within three clocks of a flag edge. A wrong reload or underflow state shows as a count other than the preset right after wrap, or as a missing or doubled `uf_pulse`. It also shows on the same edge in the `q_out` parity and a stuck `irq`. The bench drives random presets and edge counts in event mode, checks them against a wrap model, and adds directed pause, stop and gate cases.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  typedef enum logic [1:0] {
    MODE_TIME  = 2'd0,
    MODE_EVENT = 2'd1,
    MODE_PULSE = 2'd2,
    MODE_OFF   = 2'd3
  } ct_mode_e;
endpackage

// File: rtl/ptimer_sync.sv
module ptimer_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] sr;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[s] <= '0;
          else     sr[s] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sr[s] <= '0;
          else     sr[s] <= sr[s-1];
        end
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int PRESCALE = 32
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)               div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

  // R3: ticks are isolated, one per prescaler period
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
  import ptimer_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  ct_mode_e      mode,
  input  logic          start,
  input  logic          stop,
  input  logic          paused,
  input  logic          tick,
  input  logic          evt_s,
  input  logic          gate_s,
  input  logic          irq_ack,
  output logic [CW-1:0] cnt_q,
  output logic          irq_q,
  output logic          uf_q,
  output logic          tog_q
);
  logic [CW-1:0] preset_q;
  logic          run_q;
  logic          evt_d, gate_d;
  logic          evt_fall, gate_fall;
  logic          dec_en, uf_set, pulse_end;
  logic          at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_d  <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      evt_d  <= evt_s;
      gate_d <= gate_s;
    end
  end

  assign evt_fall  = evt_d & ~evt_s;
  assign gate_fall = gate_d & ~gate_s;
  assign at_zero   = (cnt_q == '0);

  always_comb begin
    unique case (mode)
      MODE_TIME:  dec_en = run_q & ~paused & tick;
      MODE_EVENT: dec_en = run_q & evt_fall;
      MODE_PULSE: dec_en = run_q & ~paused & gate_s & tick;
      default:    dec_en = 1'b0;
    endcase
  end

  assign uf_set    = dec_en & ~load_en & at_zero;
  assign pulse_end = run_q & (mode == MODE_PULSE) & gate_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      preset_q <= '0;
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
      uf_q     <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      if (load_en) begin
        preset_q <= load_val;
        cnt_q    <= load_val;
      end else if (dec_en) begin
        cnt_q <= at_zero ? preset_q : cnt_q - 1'b1;
      end

      if (stop)           run_q <= 1'b0;
      else if (start)     run_q <= 1'b1;
      else if (pulse_end) run_q <= 1'b0;

      if (uf_set | pulse_end) irq_q <= 1'b1;
      else if (irq_ack)       irq_q <= 1'b0;

      uf_q  <= uf_set;
      tog_q <= tog_q ^ uf_set;
    end
  end

  // R6: underflow leaves the preset in the count and raises the request
  p_uf_reload_r6: assert property (@(posedge clk) disable iff (rst)
    uf_q |-> (cnt_q == preset_q));
  p_uf_irq_r6: assert property (@(posedge clk) disable iff (rst)
    uf_q |-> irq_q);
  p_uf_single_r6: assert property (@(posedge clk) disable iff (rst)
    uf_q |=> !uf_q);
  // R7: request is sticky until acknowledged
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_ack) |=> irq_q);
  // R8: a stopped counter holds its value unless loaded
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load_en) |=> $stable(cnt_q));
  // R5: clock-driven modes hold during a pause
  p_pause_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (paused && mode != MODE_EVENT && !load_en) |=> $stable(cnt_q));
endmodule

// File: rtl/ptimer.sv
module ptimer
  import ptimer_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PRESCALE = 32,
  parameter int SYNC_FF  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic [1:0]    mode_sel,
  input  logic          start,
  input  logic          stop,
  input  logic          cpu_paused,
  input  logic          evt_flag,
  input  logic          gate_in,
  input  logic          irq_ack,
  input  logic          route_out,
  input  logic          gpo_val,
  output logic [CW-1:0] cnt_val,
  output logic          irq,
  output logic          uf_pulse,
  output logic          q_out
);
  logic       tick;
  logic [1:0] async_in, sync_out;
  logic       tog;
  logic       q_q;

  assign async_in = {gate_in, evt_flag};

  ptimer_sync #(.W(2), .STAGES(SYNC_FF)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (async_in),
    .dout(sync_out)
  );

  ptimer_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ptimer_core #(.CW(CW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .load_val(load_val),
    .mode    (ct_mode_e'(mode_sel)),
    .start   (start),
    .stop    (stop),
    .paused  (cpu_paused),
    .tick    (tick),
    .evt_s   (sync_out[0]),
    .gate_s  (sync_out[1]),
    .irq_ack (irq_ack),
    .cnt_q   (cnt_val),
    .irq_q   (irq),
    .uf_q    (uf_pulse),
    .tog_q   (tog)
  );

  always_ff @(posedge clk) begin
    if (rst) q_q <= 1'b0;
    else     q_q <= route_out ? tog : gpo_val;
  end

  assign q_out = q_q;

  // R10: unrouted pin follows the software level one clock later
  p_gpo_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !route_out |=> (q_out == $past(gpo_val)));
endmodule

// File: tb/ptimer_bench.sv
`timescale 1ns/100ps
module ptimer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 0, start = 0, stop = 0, cpu_paused = 0;
  logic [7:0] load_val = 0;
  logic [1:0] mode_sel = 0;
  logic       evt_flag = 1, gate_in = 0, irq_ack = 0, route_out = 1, gpo_val = 0;
  logic [7:0] cnt_val;
  logic       irq, uf_pulse, q_out;

  int checks = 0, failures = 0, uf_seen = 0;
  bit done = 0;
  logic q_exp;

  always #2.5 clk = ~clk;

  ptimer u_ptimer (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .mode_sel(mode_sel), .start(start), .stop(stop), .cpu_paused(cpu_paused),
    .evt_flag(evt_flag), .gate_in(gate_in), .irq_ack(irq_ack),
    .route_out(route_out), .gpo_val(gpo_val), .cnt_val(cnt_val),
    .irq(irq), .uf_pulse(uf_pulse), .q_out(q_out)
  );

  always @(negedge clk) if (!rst && uf_pulse) uf_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_load(logic [7:0] v);
    load_val = v; load_en = 1; cyc(1); load_en = 0;
  endtask

  task automatic do_start(); start = 1; cyc(1); start = 0; endtask
  task automatic do_stop();  stop = 1;  cyc(1); stop = 0;  endtask
  task automatic do_ack();   irq_ack = 1; cyc(1); irq_ack = 0; endtask

  // run window of exactly n clocks between the start and stop edges
  task automatic run_window(int n);
    do_start();
    if (n > 1) cyc(n - 1);
    do_stop();
  endtask

  task automatic falls(int n);
    for (int i = 0; i < n; i++) begin
      evt_flag = 0; cyc(3);
      evt_flag = 1; cyc(3);
    end
  endtask

  // wrap model: preset p, start count c, n steps
  function automatic int model_cnt(int p, int c, int n, output int ufs);
    ufs = 0;
    for (int i = 0; i < n; i++) begin
      if (c == 0) begin c = p; ufs++; end
      else c--;
    end
    return c;
  endfunction

  initial begin
    int exp_c, ufs, base, p, n;
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 cnt", cnt_val, 0);
    chk("R1 irq", irq, 0);
    chk("R1 uf", uf_pulse, 0);
    chk("R1 q", q_out, 0);
    cyc(40);
    chk("R1 stopped after reset", cnt_val, 0);

    do_load(8'd200);
    chk("R2 load", cnt_val, 200);

    mode_sel = 2'd0;
    run_window(32 * 3);
    chk("R3 time base 3 periods", cnt_val, 197);
    cyc(50);
    chk("R8 frozen after stop", cnt_val, 197);
    run_window(64);
    chk("R8 resume R3 2 periods", cnt_val, 195);

    cpu_paused = 1;
    run_window(100);
    chk("R5 time base paused", cnt_val, 195);
    cpu_paused = 0;

    mode_sel = 2'd1;
    do_load(8'd5);
    do_start();
    base = uf_seen;
    falls(4);
    chk("R4 event count", cnt_val, 1);
    cpu_paused = 1;
    falls(3);
    chk("R4 R6 count while paused with wrap", cnt_val, 4);
    chk("R6 irq set", irq, 1);
    chk("R6 one uf pulse", uf_seen - base, 1);
    chk("R10 q toggled", q_out, 1);
    cpu_paused = 0;
    cyc(20);
    chk("R7 irq sticky", irq, 1);
    do_ack();
    chk("R7 irq cleared", irq, 0);

    route_out = 0; gpo_val = 0; cyc(2);
    chk("R10 gpo low", q_out, 0);
    gpo_val = 1; cyc(2);
    chk("R10 gpo high", q_out, 1);
    route_out = 1; cyc(2);
    chk("R10 routed again", q_out, 1);

    do_stop();
    falls(3);
    chk("R8 events ignored when stopped", cnt_val, 4);

    mode_sel = 2'd2;
    do_load(8'd100);
    do_start();
    cyc(40);
    chk("R9 gate low no count", cnt_val, 100);
    gate_in = 1; cyc(64);
    gate_in = 0; cyc(8);
    chk("R9 gated count", cnt_val, 98);
    chk("R9 irq on gate end", irq, 1);
    do_ack();
    gate_in = 1; cyc(96);
    gate_in = 0; cyc(8);
    chk("R9 stopped after gate end", cnt_val, 98);
    chk("R9 no second irq", irq, 0);

    // random event-mode runs
    mode_sel = 2'd1;
    q_exp = q_out;
    void'($urandom(1234));
    for (int it = 0; it < 20; it++) begin
      p = $urandom_range(0, 15);
      n = $urandom_range(0, 40);
      cpu_paused = $urandom_range(0, 1);
      do_ack();
      do_load(p[7:0]);
      do_start();
      base = uf_seen;
      falls(n);
      cyc(2);
      exp_c = model_cnt(p, p, n, ufs);
      if (ufs % 2 == 1) q_exp = ~q_exp;
      chk("R4 R6 random count", cnt_val, exp_c);
      chk("R6 random uf pulses", uf_seen - base, ufs);
      chk("R7 random irq", irq, (ufs > 0) ? 1 : 0);
      chk("R10 random q parity", q_out, q_exp);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule